// File: doc/BRIEF.md
# Erase-Block Protection Keeper

This block keeps a protection level for every erase block of a large word-addressed flash array. It decides whether a program or erase aimed at a given address may proceed. Each block is open, held or frozen. Lock, unlock and freeze commands arrive with a word address, and the block turns that address into a block number. A change takes effect at the clock edge that accepts the command. A supply-lockout flag withholds write permission from every block while it is high, and it leaves the stored levels untouched.

The array is split into equal main blocks. One main-sized slot is cut into smaller parameter blocks. A parameter picks whether that slot sits at the highest addresses or at the lowest. Block numbers rise with address in both arrangements. At the default sizes there are 16M words, 255 main blocks of 64K words and 4 parameter blocks of 16K words, so 259 blocks in all. A query port returns the level of the block that holds any address. A separate write-check port returns the permission for a requested address.

Top module: `blk_lock_mgr`

## Requirements
- R1: Block numbers follow address. With TOP_BOOT=1, main slot s (counting 2^MAIN_SHIFT words from address 0) is block s for every slot except the last one. The last slot holds parameter blocks NSLOT-1 upward, one for each 2^PARAM_SHIFT words. With TOP_BOOT=0, slot 0 holds parameter blocks 0 to NUM_PARAM-1, and slot s>0 is block s+NUM_PARAM-1.
- R2: After reset every block reads as held (level code 2'b01), and no address is write-permitted.
- R3: A lock command (cmd_op 2'b01) moves an open block to held.
- R4: An unlock command (cmd_op 2'b10) moves a held block to open.
- R5: A freeze command (cmd_op 2'b11) moves an open or held block to frozen (level code 2'b11).
- R6: A frozen block ignores lock and unlock commands. Only reset returns it to held.
- R7: The new level shows on the query port and on wr_ok at the first clock edge after the command is presented, with no further delay.
- R8: wr_ok is 1 exactly when the block holding wr_addr is open (level code 2'b00) and vpp_low is 0.
- R9: While vpp_low is 1, wr_ok is 0 for every address, and the stored levels do not change.
- R10: A command changes only the block holding cmd_addr. A cycle with cmd_valid=0, or with cmd_op 2'b00, changes nothing.
- R11: The level code 2'b10 never appears on qry_state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous assert |
| vpp_low | input | 1 | Programming supply at or below its lockout level |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 none, 01 lock, 10 unlock, 11 freeze |
| cmd_addr | input | ADDR_W | Any word address inside the target block |
| wr_addr | input | ADDR_W | Address of a program or erase request |
| wr_ok | output | 1 | Program or erase allowed at wr_addr |
| wr_blk | output | IDX_W | Block number holding wr_addr |
| qry_addr | input | ADDR_W | Address whose block level is read |
| qry_state | output | 2 | Level of that block: 00 open, 01 held, 11 frozen |
| qry_blk | output | IDX_W | Block number holding qry_addr |

## Verification
The assertions take for granted that rst_n deasserts away from a clock edge. They also assume cmd_op, cmd_valid, cmd_addr and vpp_low are stable around each rising edge, so that a per-block state holds or steps exactly once per accepted command. The bench changes every input on the falling edge and releases reset there as well. It sweeps the query and write ports only while no command is valid. This keeps every edge inside the assumed input discipline, while all four op codes and every address still reach the design.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

  typedef enum logic [1:0] {
    LK_OPEN   = 2'b00,
    LK_HELD   = 2'b01,
    LK_FROZEN = 2'b11
  } lk_state_t;

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_LOCK   = 2'b01,
    OP_UNLOCK = 2'b10,
    OP_FREEZE = 2'b11
  } lk_op_t;

  // Next protection level of one block for one accepted command.
  function automatic lk_state_t lk_next(lk_state_t cur, lk_op_t op);
    lk_state_t nxt;
    nxt = cur;
    if (cur != LK_FROZEN) begin
      case (op)
        OP_LOCK:   nxt = LK_HELD;
        OP_UNLOCK: nxt = LK_OPEN;
        OP_FREEZE: nxt = LK_FROZEN;
        default:   nxt = cur;
      endcase
    end
    return nxt;
  endfunction

  // Write permission from a level and the supply lockout flag.
  function automatic logic lk_permit(lk_state_t st, logic vpp_low);
    return (st == LK_OPEN) && !vpp_low;
  endfunction

endpackage

// File: rtl/blk_addr_map.sv
module blk_addr_map #(
  parameter int ADDR_W      = 24,
  parameter int MAIN_SHIFT  = 16,
  parameter int PARAM_SHIFT = 14,
  parameter bit TOP_BOOT    = 1'b1,
  parameter int IDX_W       = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  blk
);
  localparam int SLOT_W    = ADDR_W - MAIN_SHIFT;
  localparam int SUB_W     = MAIN_SHIFT - PARAM_SHIFT;
  localparam int NSLOT     = 2 ** SLOT_W;
  localparam int NUM_PARAM = 2 ** SUB_W;

  logic [SLOT_W-1:0] slot;
  logic [SUB_W-1:0]  sub;

  assign slot = addr[ADDR_W-1:MAIN_SHIFT];
  assign sub  = addr[MAIN_SHIFT-1:PARAM_SHIFT];

  generate
    if (TOP_BOOT) begin : g_top
      // Parameter slot is the highest one; numbering continues upward in it.
      always_comb begin
        if (slot == SLOT_W'(NSLOT - 1))
          blk = IDX_W'(NSLOT - 1) + IDX_W'(sub);
        else
          blk = IDX_W'(slot);
      end
    end else begin : g_bottom
      // Parameter slot is slot 0; main blocks follow after them.
      always_comb begin
        if (slot == '0)
          blk = IDX_W'(sub);
        else
          blk = IDX_W'(slot) + IDX_W'(NUM_PARAM - 1);
      end
    end
  endgenerate

endmodule

// File: rtl/blk_lock_cell.sv
module blk_lock_cell
  import blk_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel,
  input  lk_op_t    op,
  output lk_state_t state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LK_HELD;
    else if (sel) state <= lk_next(state, op);
  end

  // R6: frozen persists until reset
  p_frozen_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state == LK_FROZEN |=> state == LK_FROZEN);

  // R3: lock takes an open block to held
  p_lock_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel && op == OP_LOCK && state == LK_OPEN |=> state == LK_HELD);

  // R4: unlock takes a held block to open
  p_unlock_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel && op == OP_UNLOCK && state == LK_HELD |=> state == LK_OPEN);

  // R5: freeze always ends frozen
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel && op == OP_FREEZE |=> state == LK_FROZEN);

  // R10: unselected or empty commands leave the level alone
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel || op == OP_NONE) |=> $stable(state));

endmodule

// File: rtl/blk_write_gate.sv
module blk_write_gate
  import blk_lock_pkg::*;
(
  input  lk_state_t st,
  input  logic      vpp_low,
  output logic      ok
);
  assign ok = lk_permit(st, vpp_low);
endmodule

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr
  import blk_lock_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int MAIN_SHIFT  = 16,
  parameter int PARAM_SHIFT = 14,
  parameter bit TOP_BOOT    = 1'b1,
  localparam int NUM_BLOCKS = 2 ** (ADDR_W - MAIN_SHIFT) - 1 + 2 ** (MAIN_SHIFT - PARAM_SHIFT),
  localparam int IDX_W      = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vpp_low,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              wr_ok,
  output logic [IDX_W-1:0]  wr_blk,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic [1:0]        qry_state,
  output logic [IDX_W-1:0]  qry_blk
);

  // Named internal events for checking.
  logic [IDX_W-1:0]      cmd_blk;
  logic [NUM_BLOCKS-1:0] cmd_sel;
  lk_op_t                op_q;
  lk_state_t             blk_st [NUM_BLOCKS];
  lk_state_t             wr_st;
  lk_state_t             qry_st;

  assign op_q = lk_op_t'(cmd_op);

  blk_addr_map #(.ADDR_W(ADDR_W), .MAIN_SHIFT(MAIN_SHIFT), .PARAM_SHIFT(PARAM_SHIFT),
                 .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
    u_map_cmd (.addr(cmd_addr), .blk(cmd_blk));

  blk_addr_map #(.ADDR_W(ADDR_W), .MAIN_SHIFT(MAIN_SHIFT), .PARAM_SHIFT(PARAM_SHIFT),
                 .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
    u_map_wr (.addr(wr_addr), .blk(wr_blk));

  blk_addr_map #(.ADDR_W(ADDR_W), .MAIN_SHIFT(MAIN_SHIFT), .PARAM_SHIFT(PARAM_SHIFT),
                 .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
    u_map_qry (.addr(qry_addr), .blk(qry_blk));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BLOCKS; gi++) begin : g_blk
      assign cmd_sel[gi] = cmd_valid && (cmd_blk == IDX_W'(gi));
      blk_lock_cell u_cell (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (cmd_sel[gi]),
        .op   (op_q),
        .state(blk_st[gi])
      );
    end
  endgenerate

  assign wr_st     = blk_st[wr_blk];
  assign qry_st    = blk_st[qry_blk];
  assign qry_state = qry_st;

  blk_write_gate u_gate (.st(wr_st), .vpp_low(vpp_low), .ok(wr_ok));

  // R10: a command reaches at most one block
  p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_sel));

  // R9: supply lockout blocks every write
  p_vpp_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_low |-> !wr_ok);

  // R11: no reserved level code on the query port
  p_no_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    qry_state != 2'b10);

  // R1: decoded block numbers stay inside the block count
  p_blk_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(qry_blk) < NUM_BLOCKS) && (int'(wr_blk) < NUM_BLOCKS));

endmodule

// File: tb/tb_blk_lock_mgr.sv
module tb_blk_lock_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NB = 19;       // 15 main + 4 parameter blocks
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vpp_low = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0, wr_addr = '0, qry_addr = '0;
  logic wr_ok_t, wr_ok_b;
  logic [IW-1:0] wr_blk_t, wr_blk_b, qry_blk_t, qry_blk_b;
  logic [1:0] qry_state_t, qry_state_b;

  int checks = 0, failures = 0;
  int exp_t [NB];
  int exp_b [NB];
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_lock_mgr #(.ADDR_W(AW), .MAIN_SHIFT(4), .PARAM_SHIFT(2), .TOP_BOOT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .vpp_low(vpp_low), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .wr_addr(wr_addr), .wr_ok(wr_ok_t), .wr_blk(wr_blk_t),
    .qry_addr(qry_addr), .qry_state(qry_state_t), .qry_blk(qry_blk_t));

  blk_lock_mgr #(.ADDR_W(AW), .MAIN_SHIFT(4), .PARAM_SHIFT(2), .TOP_BOOT(1'b0)) dut_bot (
    .clk(clk), .rst_n(rst_n), .vpp_low(vpp_low), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .wr_addr(wr_addr), .wr_ok(wr_ok_b), .wr_blk(wr_blk_b),
    .qry_addr(qry_addr), .qry_state(qry_state_b), .qry_blk(qry_blk_b));

  // R1 restated: 16-word slots, 4-word parameter blocks.
  function automatic int tb_blk(bit top, int a);
    int slot, sub;
    slot = a / 16;
    sub  = (a % 16) / 4;
    if (top) return (slot == 15) ? 15 + sub : slot;
    else     return (slot == 0) ? sub : slot + 3;
  endfunction

  // Levels: 0 open, 1 held, 3 frozen.
  function automatic int tb_next(int cur, int op);
    if (cur == 3) return 3;
    if (op == 1) return 1;
    if (op == 2) return 0;
    if (op == 3) return 3;
    return cur;
  endfunction

  task automatic check(string tag, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin exp_t[i] = 1; exp_b[i] = 1; end
  endtask

  // Full address sweep of both ports on both variants; no command in flight.
  task automatic sweep(string tag);
    for (int a = 0; a < 256; a++) begin
      int bt, bb;
      qry_addr = AW'(a);
      wr_addr  = AW'(a);
      #1;
      bt = tb_blk(1'b1, a);
      bb = tb_blk(1'b0, a);
      check("R1", int'(qry_blk_t), bt, "top qry_blk");
      check("R1", int'(wr_blk_b), bb, "bottom wr_blk");
      check(tag, int'(qry_state_t), exp_t[bt], "top qry_state");
      check(tag, int'(qry_state_b), exp_b[bb], "bottom qry_state");
      check("R8", int'(wr_ok_t), (exp_t[bt] == 0 && !vpp_low) ? 1 : 0, "top wr_ok");
      check("R8", int'(wr_ok_b), (exp_b[bb] == 0 && !vpp_low) ? 1 : 0, "bottom wr_ok");
    end
  endtask

  // Present one command on a falling edge; check its block right after the next rise.
  task automatic do_cmd(bit v, int op, int a, bit vpp);
    @(negedge clk);
    cmd_valid = v; cmd_op = 2'(op); cmd_addr = AW'(a); vpp_low = vpp;
    if (v) begin
      exp_t[tb_blk(1'b1, a)] = tb_next(exp_t[tb_blk(1'b1, a)], op);
      exp_b[tb_blk(1'b0, a)] = tb_next(exp_b[tb_blk(1'b0, a)], op);
    end
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    qry_addr = AW'(a);
    #1;
    // R7: effect visible at the first edge after the command
    check("R7", int'(qry_state_t), exp_t[tb_blk(1'b1, a)], "top level after edge");
    check("R7", int'(qry_state_b), exp_b[tb_blk(1'b0, a)], "bottom level after edge");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0; vpp_low = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    model_reset();
    do_reset();
    // R2: everything held after power-up
    sweep("R2");

    // Pseudo-random sweep of ops, addresses, valid and lockout (R3 R4 R5 R6 R9 R10 R11).
    lf = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_cmd(lf[14] | lf[15], int'(lf[1:0]), int'(lf[9:2]), lf[12] & lf[13]);
      if (n % 10 == 9) sweep("R10");
      if (n == 150) do_reset();
    end
    sweep("R10");

    // Directed: boundary blocks of both arrangements.
    do_reset();
    do_cmd(1'b1, 2, 255, 1'b0);          // R4: top param block 18 / bottom main 18
    check("R4", int'(qry_state_t), 0, "top last param block open");
    do_cmd(1'b1, 2, 0, 1'b0);            // R4: first block
    check("R4", int'(qry_state_b), 0, "bottom first param block open");
    do_cmd(1'b1, 1, 0, 1'b0);            // R3
    check("R3", int'(qry_state_t), 1, "relock block 0");
    do_cmd(1'b1, 2, 0, 1'b0);
    sweep("R4");

    // R9: lockout hides permission but keeps levels.
    do_cmd(1'b0, 0, 0, 1'b1);
    wr_addr = '0; #1;
    check("R9", int'(wr_ok_t), 0, "lockout wr_ok top");
    check("R9", int'(wr_ok_b), 0, "lockout wr_ok bottom");
    sweep("R9");
    do_cmd(1'b0, 0, 0, 1'b0);
    wr_addr = '0; #1;
    check("R9", int'(wr_ok_t), 1, "permission back after lockout");

    // R5 / R6: freeze, then lock and unlock ignored; reset clears.
    do_cmd(1'b1, 3, 0, 1'b0);
    check("R5", int'(qry_state_t), 3, "open to frozen");
    do_cmd(1'b1, 3, 100, 1'b0);
    check("R5", int'(qry_state_t), 3, "held to frozen");
    do_cmd(1'b1, 2, 0, 1'b0);
    check("R6", int'(qry_state_t), 3, "unlock ignored when frozen");
    do_cmd(1'b1, 1, 0, 1'b0);
    check("R6", int'(qry_state_b), 3, "lock ignored when frozen");
    do_cmd(1'b1, 0, 255, 1'b0);           // R10: op none
    sweep("R11");
    do_reset();
    qry_addr = '0; #1;
    check("R6", int'(qry_state_t), 1, "reset leaves frozen");
    sweep("R2");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule